// File: doc/BRIEF.md
# Bit-Stuffing NRZI Frame Transmitter

This block turns a byte stream of packets into a single serial line for a synchronous link whose receiver recovers its clock from line transitions. Between packets it sends the flag pattern 0x7E over and over. When a packet is offered, it is sent after the end of a flag. A 16-bit frame check sequence follows the packet, and then a closing flag.

Inside a frame every bit is counted in runs. After five equal bits in a row, one bit of the opposite value is inserted. Long runs of ones and long runs of zeros are therefore both broken up. Flags are exempt from this rule, which is how a receiver tells them apart from frame content. The resulting bit stream is then line-coded so that zeros appear as level changes. One line bit is produced on each cycle where the bit-clock enable is high.

The producer sees a valid/ready byte handshake with start and end markers. `in_ready` is asserted only on the bit-time where a new byte is serialised, so the stream throttles itself to the line rate and to the inserted bits.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, the transmitted bit stream is the flag 0x7E repeated, sent LSB first. Flag bits are never stuffed, so each flag carries six 1s in a row.
- R2: `line_out` is low after reset. A transmitted 0 bit toggles `line_out` on that bit-time, and a transmitted 1 bit leaves it unchanged. The line state carries over across flags and packets.
- R3: Between an opening and a closing flag, covering payload and check bytes, an opposite-valued bit is inserted after any five consecutive equal bits. That inserted bit counts as the first bit of a new run. `in_ready` is low on the bit-time of an inserted bit.
- R4: Run counting restarts at the end of every flag. A run that is still pending when the check bytes finish is stuffed before the closing flag begins.
- R5: `in_ready` is high only on a bit-time at a byte boundary of an open packet, or on the last bit of a flag. A byte transfers when `in_valid` and `in_ready` are both high, and its bit 0 goes out on that same bit-time. Bytes are sent LSB first.
- R6: A packet opens at the end of any flag if `in_valid` and `in_sop` are both high. A byte offered at the end of a flag with `in_sop` low is consumed and discarded.
- R7: After a byte marked with `in_eop` has been sent, the two check bytes follow directly, and then one closing flag.
- R8: The check value is CRC-16 with polynomial 0x1021, processed LSB first (reflected 0x8408), preset 0xFFFF. It is computed over the unstuffed payload bits, complemented, and sent low byte first, LSB first.
- R9: If `in_valid` is low at a byte boundary of an open packet, the packet closes at that point and the check bytes start on the same bit-time.
- R10: Nothing advances on a cycle where `bit_en` is low: `line_out` holds and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One line bit-time per cycle where high |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_ready | output | 1 | Byte taken on this cycle if valid |
| line_out | output | 1 | Line-coded serial output |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit check value, a run limit of five, and the 0x7E flag. With these values, all-ones and all-zeros bytes reach the stuffing threshold within one byte. A zero-led or one-led first byte also tests whether runs carry across the flag boundary, and the standard nine-byte ASCII test string lets the check value be compared against the well-known CRC-16 result. Throttled enables at 40% density show that the line holds and the handshake stays silent between bit-times.

// File: rtl/nst_pkg.sv
package nst_pkg;
  typedef enum logic [1:0] {
    S_FLAG = 2'd0,
    S_DATA = 2'd1,
    S_CRC  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/nst_run_limiter.sv
// Tracks the run of equal bits and requests an inserted bit at the limit.
module nst_run_limiter #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_in,
  input  logic hold,
  input  logic clear,
  output logic stuff,
  output logic stuff_bit
);
  localparam int LW = $clog2(RUN_MAX + 1);

  logic [LW-1:0] len_q;
  logic          val_q;

  assign stuff     = (len_q == LW'(RUN_MAX));
  assign stuff_bit = ~val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      val_q <= 1'b0;
    end else if (en) begin
      if (stuff) begin
        val_q <= ~val_q;
        len_q <= LW'(1);
      end else if (clear) begin
        len_q <= '0;
      end else if (!hold) begin
        if (len_q != '0 && bit_in == val_q) begin
          len_q <= len_q + LW'(1);
        end else begin
          val_q <= bit_in;
          len_q <= LW'(1);
        end
      end
    end
  end

  // R3: an inserted bit starts a fresh run of the opposite value
  p_stuff_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    (en && stuff) |=> (len_q == LW'(1)) && (val_q != $past(val_q)));
endmodule

// File: rtl/nst_crc.sv
// Bit-serial reflected CRC: preset, accumulate, then shift out complemented.
module nst_crc #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic         calc,
  input  logic         shift,
  input  logic         bit_in,
  output logic         tx_bit,
  output logic [W-1:0] crc_q
);
  assign tx_bit = ~crc_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= INIT;
    end else if (en) begin
      if (load) begin
        crc_q <= INIT;
      end else if (calc) begin
        crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_in) ? POLY : '0);
      end else if (shift) begin
        crc_q <= crc_q >> 1;
      end
    end
  end
endmodule

// File: rtl/nst_nrzi.sv
// Differential line coder: a zero bit is a level change.
module nst_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_in,
  output logic line_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else if (en && !bit_in) begin
      line_q <= ~line_q;
    end
  end

  // R10: the line holds between bit-times
  p_line_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(line_q));
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx #(
  parameter int                DATA_W   = 8,
  parameter int                CRC_W    = 16,
  parameter int                RUN_MAX  = 5,
  parameter logic [DATA_W-1:0] FLAG     = 8'h7E,
  parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              line_out
);
  import nst_pkg::*;

  localparam int SPAN = (CRC_W > DATA_W) ? CRC_W : DATA_W;
  localparam int CW   = $clog2(SPAN);
  localparam int BW   = $clog2(DATA_W);

  tx_state_e         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              last_q, last_n;

  logic              stuff, stuff_bit, tx_bit, hold, clr;
  logic              crc_load, crc_calc, crc_shift, crc_bit, ready_c;
  logic [CRC_W-1:0]  crc_q;

  always_comb begin
    tx_bit    = stuff_bit;
    hold      = 1'b0;
    clr       = 1'b0;
    crc_load  = 1'b0;
    crc_calc  = 1'b0;
    crc_shift = 1'b0;
    ready_c   = 1'b0;
    st_n      = st_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    last_n    = last_q;
    if (!stuff) begin
      case (st_q)
        S_FLAG: begin
          tx_bit = FLAG[cnt_q[BW-1:0]];
          hold   = 1'b1;
          if (cnt_q == CW'(DATA_W - 1)) begin
            clr   = 1'b1;
            cnt_n = '0;
            if (in_valid && in_sop) begin
              st_n     = S_DATA;
              crc_load = 1'b1;
            end else begin
              ready_c = !in_sop;
            end
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        S_DATA: begin
          if (cnt_q == '0) begin
            ready_c = 1'b1;
            cnt_n   = CW'(1);
            if (in_valid) begin
              tx_bit   = in_data[0];
              crc_calc = 1'b1;
              sh_n     = in_data;
              last_n   = in_eop;
            end else begin
              tx_bit    = crc_bit;
              crc_shift = 1'b1;
              st_n      = S_CRC;
            end
          end else begin
            tx_bit   = sh_q[cnt_q[BW-1:0]];
            crc_calc = 1'b1;
            if (cnt_q == CW'(DATA_W - 1)) begin
              cnt_n = '0;
              if (last_q) begin
                st_n   = S_CRC;
                last_n = 1'b0;
              end
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end
        end
        default: begin
          tx_bit    = crc_bit;
          crc_shift = 1'b1;
          if (cnt_q == CW'(CRC_W - 1)) begin
            st_n  = S_FLAG;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  assign in_ready = bit_en & ready_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_FLAG;
      cnt_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
    end else if (bit_en) begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      last_q <= last_n;
    end
  end

  nst_run_limiter #(.RUN_MAX(RUN_MAX)) run_i (
    .clk(clk), .rst(rst), .en(bit_en), .bit_in(tx_bit),
    .hold(hold), .clear(clr), .stuff(stuff), .stuff_bit(stuff_bit)
  );

  nst_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst(rst), .en(bit_en), .load(crc_load), .calc(crc_calc),
    .shift(crc_shift), .bit_in(tx_bit), .tx_bit(crc_bit), .crc_q(crc_q)
  );

  nst_nrzi nrzi_i (
    .clk(clk), .rst(rst), .en(bit_en), .bit_in(tx_bit), .line_q(line_out)
  );

  // R3: no byte is taken on an inserted bit
  p_ready_not_on_stuff_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !stuff);

  // R10: the handshake is silent between bit-times
  p_ready_needs_bit_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |-> !in_ready);

  // R8: a freshly opened packet starts from the preset check value
  p_open_preset_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DATA && cnt_q == '0 && $past(st_q) == S_FLAG) |-> crc_q == CRC_INIT);

  // R7: once the check bytes start, the next state is either more check bits or a flag
  p_crc_exits_to_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_CRC) |=> (st_q == S_CRC || st_q == S_FLAG));
endmodule

// File: tb/nrzi_stuff_tx_tb_top.sv
module nrzi_stuff_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic       in_ready, line_out;

  always #5 clk = ~clk;

  nrzi_stuff_tx dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready), .line_out(line_out)
  );

  int n_chk = 0, n_fail = 0;

  // source queues
  bit [7:0] sq_d[$];
  bit       sq_s[$], sq_e[$];

  // behavioural reference state
  int       ph = 0;     // 0 flag, 1 payload, 2 check bytes
  int       fidx = 0;
  int       run = 0;
  bit       rv = 1'b0;
  bit       exp_line = 1'b0, exp_ready = 1'b0, m_last = 1'b0, prev_en = 1'b0;
  bit       mq[$];
  bit [7:0] pkt[$];
  string    ctx = "R1", scen = "R1";

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic bit [15:0] fcs(input bit [7:0] b[$]);
    bit [15:0] c = 16'hFFFF;
    foreach (b[k]) begin
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ b[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  task automatic push_check();
    bit [15:0] f = fcs(pkt);
    for (int i = 0; i < 16; i++) mq.push_back(f[i]);
    ph = 2;
  endtask

  task automatic model_step();
    bit b;
    exp_ready = 1'b0;
    if (run == 5) begin
      b = ~rv; rv = ~rv; run = 1; ctx = "R3";
    end else begin
      if (ph == 1 && mq.size() == 0) begin
        if (m_last) push_check();
        else begin
          exp_ready = 1'b1;
          if (in_valid) begin
            pkt.push_back(in_data);
            for (int i = 0; i < 8; i++) mq.push_back(in_data[i]);
            m_last = in_eop;
          end else push_check();
        end
      end else if (ph == 2 && mq.size() == 0) begin
        ph = 0; fidx = 0;
      end
      if (ph == 0) begin
        b = (8'h7E >> fidx) & 1; ctx = "R1";
        if (fidx == 7) begin
          run = 0;
          if (in_valid && in_sop) begin
            ph = 1; pkt.delete(); m_last = 1'b0;
          end else exp_ready = !in_sop;
        end
        fidx = (fidx + 1) % 8;
      end else begin
        b = mq.pop_front();
        ctx = (ph == 2) ? "R8" : "R5";
        if (run != 0 && b == rv) run++;
        else begin rv = b; run = 1; end
      end
    end
    if (!b) exp_line = ~exp_line;
  endtask

  task automatic cyc(input bit en);
    @(negedge clk);
    chk(line_out, exp_line, prev_en ? {"R2 ", ctx, " ", scen} : {"R10 ", scen});
    bit_en   = en;
    in_valid = sq_d.size() > 0;
    in_data  = sq_d.size() > 0 ? sq_d[0] : 8'h00;
    in_sop   = sq_s.size() > 0 ? sq_s[0] : 1'b0;
    in_eop   = sq_e.size() > 0 ? sq_e[0] : 1'b0;
    #1;
    if (en) model_step(); else exp_ready = 1'b0;
    chk(in_ready, exp_ready, en ? {"R5 ", scen} : "R10");
    if (in_ready && in_valid) begin
      void'(sq_d.pop_front()); void'(sq_s.pop_front()); void'(sq_e.pop_front());
    end
    prev_en = en;
  endtask

  task automatic send(input bit [7:0] b[$], input bit with_eop);
    foreach (b[k]) begin
      sq_d.push_back(b[k]);
      sq_s.push_back(k == 0);
      sq_e.push_back(with_eop && k == b.size() - 1);
    end
  endtask

  task automatic drain(input int pct);
    int guard = 0;
    while ((sq_d.size() != 0 || ph != 0) && guard < 20000) begin
      cyc($urandom_range(99) < pct);
      guard++;
    end
    repeat (30) cyc($urandom_range(99) < pct);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [7:0] p[$];
    repeat (3) @(negedge clk);
    chk(line_out, 1'b0, "R2 reset level");
    chk(in_ready, 1'b0, "R5 reset ready");
    rst = 1'b0;

    scen = "R1"; repeat (40) cyc(1'b1);

    scen = "R3"; p = '{8'hFF, 8'hFF, 8'hFF}; send(p, 1'b1); drain(100);
    p = '{8'h00, 8'h00, 8'h00}; send(p, 1'b1); drain(100);

    scen = "R4"; p = '{8'h00, 8'hF0}; send(p, 1'b1); drain(100);
    p = '{8'h1F}; send(p, 1'b1); drain(100);

    scen = "R6";
    sq_d.push_back(8'h55); sq_s.push_back(1'b0); sq_e.push_back(1'b0);
    p = '{8'hA5, 8'h3C}; send(p, 1'b1); drain(100);
    chk(sq_d.size() == 0, 1'b1, "R6 source drained");

    scen = "R7"; p = '{8'h81}; send(p, 1'b1); drain(100);

    scen = "R8"; p = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send(p, 1'b1); drain(100);
    chk(fcs(p) == 16'h906E ? 1'b1 : 1'b0, 1'b1, "R8 check value");

    scen = "R9"; p = '{8'h12, 8'h34, 8'h56}; send(p, 1'b0); drain(100);

    scen = "R10";
    for (int k = 0; k < 6; k++) begin
      p.delete();
      for (int j = 0; j <= k; j++) p.push_back(8'($urandom_range(255)));
      send(p, 1'b1);
    end
    drain(40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule